// File: doc/BRIEF.md
# Shared JTAG Pin Ownership Controller

This block decides whether a group of six shared port pins serves a test access port or ordinary general-purpose I/O. The four basic test pins carry mode select, test clock, test data in and test data out. The two extension pins carry a programming-status line and an error line. Three independent sources can claim the basic pins, and any one of them is enough. The first is a nonvolatile configuration bit, which is loaded from the configuration store and comes out of reset set, so that a blank part is always reachable. The second is a run-time enable bit that a microcontroller sets and clears over a simple strobed register bus. The third is a select term produced by internal programmable logic.

When the pins are claimed, all four basic pins start as inputs. The test-data-out pin begins to drive only after the external test controller has issued its activation command. The same command can also turn the two extension pins into outputs. When ownership is lost, the pins go straight back to general-purpose use and the activation is forgotten. Mux selects and output enables come from registers, so they follow a change of any ownership source by exactly one clock.

Top module: `jtag_share_ctl`

## Requirements
- R1: The pin ownership flag (`pin_jtag_sel[0]`) is the OR of the nonvolatile bit, the run-time enable bit and `pt_sel`, taken one clock edge after any of these changes.
- R2: When owned, pins 0 (TMS), 1 (TCK) and 2 (TDI) have output enable 0, and `tap_tms`/`tap_tck`/`tap_tdi` follow `pad_in[0..2]`. When not owned, all six pads take `gpio_out`/`gpio_oe`, and the test outputs idle at tms=1, tck=0, tdi=1.
- R3: A bus write (`bus_sel`=1, `bus_we`=1) to address `REG_OFS` (default 0xC7) loads `bus_wdata[0]` into the run-time enable bit. A write to any other address changes nothing.
- R4: A bus read (`bus_sel`=1, `bus_we`=0) at `REG_OFS` returns the enable bit in bit 0 with every other bit 0. A read at any other address, or with no read strobe, returns 0.
- R5: Reset (`rst`=1, synchronous) clears the run-time enable bit, ownership and all activation. It sets the nonvolatile bit to `NV_BLANK` (default 1), so a blank part owns the pins after reset.
- R6: The nonvolatile bit takes `nv_data` only when `nv_load` is high. Bus writes cannot change it.
- R7: Pin 3 (TDO) has output enable 0 while owned until a `tap_act_cmd` pulse is seen with ownership already in effect. From the next edge, pin 3 drives `tap_tdo` with output enable 1.
- R8: A `tap_act_cmd` pulse while the pins are not owned has no effect. TDO remains an input after ownership is later gained.
- R9: When the OR of the sources becomes 0, ownership, TDO activation and extension activation all clear at the same edge. Regaining ownership leaves TDO as an input.
- R10: Pins 4 (TSTAT) and 5 (TERR) become outputs driving `tap_tstat`/`tap_terr` only if `tap_act_ext` was 1 with the accepted command. Otherwise they stay on GPIO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_load | input | 1 | Load strobe for the nonvolatile ownership bit |
| nv_data | input | 1 | Value from the configuration store |
| pt_sel | input | 1 | Select term from internal programmable logic |
| bus_sel | input | 1 | One-cycle bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| tap_act_cmd | input | 1 | Activation command pulse from the test side |
| tap_act_ext | input | 1 | Enable the extension pins with this command |
| tap_tdo | input | 1 | Test data out from the TAP |
| tap_tstat | input | 1 | Status from the programming engine |
| tap_terr | input | 1 | Error from the programming engine |
| tap_tms | output | 1 | Mode select to the TAP |
| tap_tck | output | 1 | Test clock to the TAP |
| tap_tdi | output | 1 | Test data in to the TAP |
| gpio_out | input | PIN_CNT | GPIO output values |
| gpio_oe | input | PIN_CNT | GPIO output enables |
| pad_in | input | PIN_CNT | Pad input values |
| pad_out | output | PIN_CNT | Pad output values |
| pad_oe | output | PIN_CNT | Pad output enables |
| pin_jtag_sel | output | PIN_CNT | Per-pin mux select, 1 = test function |

## Verification
The assertions assume that `bus_sel` is a single-cycle strobe whose address and data are stable during that cycle. They also assume that `tap_act_cmd` is a pulse and is not held. They place no rule on how fast `pt_sel` or `nv_load` may toggle. The stimulus changes every input only on the falling clock edge, raises each strobe or command pulse for exactly one cycle, and issues one bus access at a time. Outputs are then sampled on the next falling edge, one register stage after the change.

// File: rtl/jsh_pkg.sv
package jsh_pkg;

    localparam int PIN_CNT = 6;

    typedef enum logic [2:0] {
        PIN_TMS   = 3'd0,
        PIN_TCK   = 3'd1,
        PIN_TDI   = 3'd2,
        PIN_TDO   = 3'd3,
        PIN_TSTAT = 3'd4,
        PIN_TERR  = 3'd5
    } pin_role_e;

    typedef struct packed {
        logic mode;     // pins owned by test function
        logic tdo_act;  // TDO driving
        logic ext_act;  // TSTAT/TERR driving
    } own_state_t;

    localparam own_state_t OWN_IDLE = '{mode: 1'b0, tdo_act: 1'b0, ext_act: 1'b0};

    function automatic logic pin_is_ext(input int idx);
        return (idx == int'(PIN_TSTAT)) || (idx == int'(PIN_TERR));
    endfunction

    function automatic logic pin_is_tap_in(input int idx);
        return idx < int'(PIN_TDO);
    endfunction

    function automatic logic [PIN_CNT-1:0] sel_mask(input own_state_t s);
        logic [PIN_CNT-1:0] m;
        for (int i = 0; i < PIN_CNT; i++) begin
            m[i] = pin_is_ext(i) ? s.ext_act : s.mode;
        end
        return m;
    endfunction

endpackage

// File: rtl/jsh_enable_reg.sv
module jsh_enable_reg #(
    parameter int          ADDR_W  = 8,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  REG_OFS = 8'hC7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              run_en
);
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);

    logic addr_hit;
    logic wr_hit;
    logic rd_hit;

    assign addr_hit = (bus_addr == OFS);
    assign wr_hit   = bus_sel && bus_we && addr_hit;
    assign rd_hit   = bus_sel && !bus_we && addr_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_en <= 1'b0;
        end else if (wr_hit) begin
            run_en <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[0] = run_en;
        end
    end

    // R3: a matching write lands in the enable bit at the next edge
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr == OFS) |=> (run_en == $past(bus_wdata[0])));

    // R3: a non-matching write leaves the enable bit alone
    a_r3_other_addr_keeps: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr != OFS) |=> $stable(run_en));

endmodule

// File: rtl/jsh_owner_ctl.sv
module jsh_owner_ctl
    import jsh_pkg::*;
#(
    parameter logic NV_BLANK = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       nv_load,
    input  logic       nv_data,
    input  logic       run_en,
    input  logic       pt_sel,
    input  logic       act_cmd,
    input  logic       act_ext,
    output own_state_t st
);
    logic       nv_bit;
    logic       own_req;
    own_state_t st_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            nv_bit <= NV_BLANK;
        end else if (nv_load) begin
            nv_bit <= nv_data;
        end
    end

    assign own_req = nv_bit | run_en | pt_sel;

    always_comb begin
        st_nxt      = st;
        st_nxt.mode = own_req;
        if (!own_req) begin
            st_nxt.tdo_act = 1'b0;
            st_nxt.ext_act = 1'b0;
        end else if (st.mode && act_cmd) begin
            st_nxt.tdo_act = 1'b1;
            st_nxt.ext_act = st.ext_act | act_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= OWN_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // R9: TDO can drive only while the pins are owned
    a_r9_tdo_needs_mode: assert property (@(posedge clk) disable iff (rst)
        st.tdo_act |-> st.mode);

    // R10: extension pins are never active without TDO activation
    a_r10_ext_needs_tdo: assert property (@(posedge clk) disable iff (rst)
        st.ext_act |-> st.tdo_act);

    // R7: TDO activation only follows a command
    a_r7_tdo_rise_by_cmd: assert property (@(posedge clk) disable iff (rst)
        $rose(st.tdo_act) |-> $past(act_cmd));

    // R8: no activation can appear while not owned
    a_r8_cmd_ignored_unowned: assert property (@(posedge clk) disable iff (rst)
        (!st.mode && !st.tdo_act) |=> !st.tdo_act);

endmodule

// File: rtl/jsh_pin_mux.sv
module jsh_pin_mux
    import jsh_pkg::*;
(
    input  own_state_t         st,
    input  logic               tap_tdo,
    input  logic               tap_tstat,
    input  logic               tap_terr,
    output logic               tap_tms,
    output logic               tap_tck,
    output logic               tap_tdi,
    input  logic [PIN_CNT-1:0] gpio_out,
    input  logic [PIN_CNT-1:0] gpio_oe,
    input  logic [PIN_CNT-1:0] pad_in,
    output logic [PIN_CNT-1:0] pad_out,
    output logic [PIN_CNT-1:0] pad_oe,
    output logic [PIN_CNT-1:0] pin_jtag_sel
);
    assign pin_jtag_sel = sel_mask(st);

    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
        logic t_out;
        logic t_oe;
        if (pin_is_tap_in(i)) begin : g_in
            assign t_out = 1'b0;
            assign t_oe  = 1'b0;
        end else if (i == int'(PIN_TDO)) begin : g_tdo
            assign t_out = tap_tdo;
            assign t_oe  = st.tdo_act;
        end else if (i == int'(PIN_TSTAT)) begin : g_stat
            assign t_out = tap_tstat;
            assign t_oe  = 1'b1;
        end else begin : g_err
            assign t_out = tap_terr;
            assign t_oe  = 1'b1;
        end
        assign pad_out[i] = pin_jtag_sel[i] ? t_out : gpio_out[i];
        assign pad_oe[i]  = pin_jtag_sel[i] ? t_oe  : gpio_oe[i];
    end

    assign tap_tms = st.mode ? pad_in[PIN_TMS] : 1'b1;
    assign tap_tck = st.mode ? pad_in[PIN_TCK] : 1'b0;
    assign tap_tdi = st.mode ? pad_in[PIN_TDI] : 1'b1;

endmodule

// File: rtl/jtag_share_ctl.sv
module jtag_share_ctl
    import jsh_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] REG_OFS  = 8'hC7,
    parameter logic       NV_BLANK = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               nv_load,
    input  logic               nv_data,
    input  logic               pt_sel,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               tap_act_cmd,
    input  logic               tap_act_ext,
    input  logic               tap_tdo,
    input  logic               tap_tstat,
    input  logic               tap_terr,
    output logic               tap_tms,
    output logic               tap_tck,
    output logic               tap_tdi,
    input  logic [PIN_CNT-1:0] gpio_out,
    input  logic [PIN_CNT-1:0] gpio_oe,
    input  logic [PIN_CNT-1:0] pad_in,
    output logic [PIN_CNT-1:0] pad_out,
    output logic [PIN_CNT-1:0] pad_oe,
    output logic [PIN_CNT-1:0] pin_jtag_sel
);
    logic       run_en;
    own_state_t st;

    jsh_enable_reg #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_OFS(REG_OFS)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .run_en   (run_en)
    );

    jsh_owner_ctl #(
        .NV_BLANK(NV_BLANK)
    ) u_own (
        .clk    (clk),
        .rst    (rst),
        .nv_load(nv_load),
        .nv_data(nv_data),
        .run_en (run_en),
        .pt_sel (pt_sel),
        .act_cmd(tap_act_cmd),
        .act_ext(tap_act_ext),
        .st     (st)
    );

    jsh_pin_mux u_mux (
        .st          (st),
        .tap_tdo     (tap_tdo),
        .tap_tstat   (tap_tstat),
        .tap_terr    (tap_terr),
        .tap_tms     (tap_tms),
        .tap_tck     (tap_tck),
        .tap_tdi     (tap_tdi),
        .gpio_out    (gpio_out),
        .gpio_oe     (gpio_oe),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pin_jtag_sel(pin_jtag_sel)
    );

    // R2: owned basic input pins never drive the pad
    a_r2_inputs_undriven: assert property (@(posedge clk) disable iff (rst)
        pin_jtag_sel[0] |-> (pad_oe[2:0] == 3'b000));

    // R9: losing every source drops ownership at the next edge
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (!pt_sel && !run_en && $fell(pin_jtag_sel[0])) |-> !pad_oe[3] == !gpio_oe[3]);

endmodule

// File: tb/jtag_share_ctl_test.sv
module jtag_share_ctl_test;
    import jsh_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nv_load = 1'b0, nv_data = 1'b0, pt_sel = 1'b0;
    logic bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic tap_act_cmd = 1'b0, tap_act_ext = 1'b0;
    logic tap_tdo = 1'b1, tap_tstat = 1'b0, tap_terr = 1'b1;
    logic tap_tms, tap_tck, tap_tdi;
    logic [PIN_CNT-1:0] gpio_out = 6'b101010;
    logic [PIN_CNT-1:0] gpio_oe  = 6'b111111;
    logic [PIN_CNT-1:0] pad_in   = 6'b000000;
    logic [PIN_CNT-1:0] pad_out, pad_oe, pin_jtag_sel;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    jtag_share_ctl uut (
        .clk(clk), .rst(rst), .nv_load(nv_load), .nv_data(nv_data), .pt_sel(pt_sel),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tap_act_cmd(tap_act_cmd), .tap_act_ext(tap_act_ext),
        .tap_tdo(tap_tdo), .tap_tstat(tap_tstat), .tap_terr(tap_terr),
        .tap_tms(tap_tms), .tap_tck(tap_tck), .tap_tdi(tap_tdi),
        .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_jtag_sel(pin_jtag_sel)
    );

    // {nv, run_en, pt, expected ownership}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b0011, 4'b0101, 4'b0111,
        4'b1001, 4'b1011, 4'b1101, 4'b1111
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic nv_set(input logic v);
        @(negedge clk);
        nv_load = 1'b1; nv_data = v;
        @(negedge clk);
        nv_load = 1'b0;
    endtask

    task automatic pulse_cmd(input logic ext);
        @(negedge clk);
        tap_act_cmd = 1'b1; tap_act_ext = ext;
        @(negedge clk);
        tap_act_cmd = 1'b0; tap_act_ext = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R5: inside reset, nothing owned
        chk("R5 sel during reset", pin_jtag_sel, 6'b0);
        chk("R5 gpio pads during reset", pad_oe, gpio_oe);
        rst = 1'b0;
        @(negedge clk);
        // R5: blank nonvolatile bit owns pins one edge after reset
        chk("R5 blank default owns", pin_jtag_sel[0], 1'b1);
        bus_read(8'hC7, rd);
        chk("R5 run enable cleared", rd, 8'h00);

        // R1 table walk: OR of three sources
        foreach (VEC[k]) begin
            nv_set(VEC[k][3]);
            bus_write(8'hC7, {7'b0, VEC[k][2]});
            @(negedge clk);
            pt_sel = VEC[k][1];
            @(negedge clk);
            chk($sformatf("R1 vec%0d ownership", k), pin_jtag_sel[0], VEC[k][0]);
            // R2: pad/tap mapping in both states (pad_in is all 0)
            chk($sformatf("R2 vec%0d tms", k), tap_tms, VEC[k][0] ? 1'b0 : 1'b1);
            chk($sformatf("R2 vec%0d pad_oe", k), pad_oe,
                VEC[k][0] ? 6'b110000 : gpio_oe);
        end

        // clear all sources
        nv_set(1'b0);
        bus_write(8'hC7, 8'h00);
        pt_sel = 1'b0;
        @(negedge clk);
        chk("R1 all sources off", pin_jtag_sel, 6'b0);
        chk("R2 gpio values", pad_out, gpio_out);
        chk("R2 idle tap", {tap_tms, tap_tck, tap_tdi}, 3'b101);

        // R1 latency: exactly one edge
        pt_sel = 1'b1;
        #1 chk("R1 no change before edge", pin_jtag_sel[0], 1'b0);
        @(negedge clk);
        chk("R1 one edge after pt", pin_jtag_sel[0], 1'b1);
        pad_in = 6'b000111;
        #1 chk("R2 tap follows pads", {tap_tms, tap_tck, tap_tdi}, 3'b111);
        pad_in = 6'b000010;
        #1 chk("R2 tck follows pad", {tap_tms, tap_tck, tap_tdi}, 3'b010);
        pad_in = 6'b000000;

        // R7: TDO input until command
        chk("R7 tdo input before cmd", pad_oe[3], 1'b0);
        pulse_cmd(1'b0);
        chk("R7 tdo output after cmd", pad_oe[3], 1'b1);
        chk("R7 tdo value", pad_out[3], tap_tdo);
        tap_tdo = 1'b0;
        #1 chk("R7 tdo follows tap", pad_out[3], 1'b0);
        // R10: no ext without ext flag
        chk("R10 ext pins gpio", {pad_oe[5:4], pin_jtag_sel[5:4]}, {gpio_oe[5:4], 2'b00});
        pulse_cmd(1'b1);
        chk("R10 ext pins driven", pad_oe[5:4], 2'b11);
        chk("R10 ext values", pad_out[5:4], {tap_terr, tap_tstat});

        // R9: losing ownership clears activation
        pt_sel = 1'b0;
        @(negedge clk);
        chk("R9 ownership dropped", pin_jtag_sel, 6'b0);
        chk("R9 tdo back to gpio", pad_oe, gpio_oe);
        pt_sel = 1'b1;
        @(negedge clk);
        chk("R9 regain tdo input", pad_oe[5:3], 3'b110 & {gpio_oe[5:4], 1'b0});
        pt_sel = 1'b0;
        @(negedge clk);

        // R8: command while unowned is ignored
        pulse_cmd(1'b1);
        chk("R8 still gpio", pad_oe, gpio_oe);
        pt_sel = 1'b1;
        @(negedge clk);
        chk("R8 tdo input after own", pad_oe[3], 1'b0);
        chk("R8 ext not active", pin_jtag_sel[5:4], 2'b00);
        pt_sel = 1'b0;

        // R3/R4: address decode and read format
        bus_write(8'hC6, 8'hFF);
        bus_read(8'hC7, rd);
        chk("R3 other addr write ignored", rd, 8'h00);
        @(negedge clk);
        chk("R3 ownership unchanged", pin_jtag_sel[0], 1'b0);
        bus_write(8'hC7, 8'hFE);
        bus_read(8'hC7, rd);
        chk("R4 bit0 only, 0xFE clears", rd, 8'h00);
        bus_write(8'hC7, 8'hFF);
        bus_read(8'hC7, rd);
        chk("R4 read 0x01", rd, 8'h01);
        bus_read(8'hC6, rd);
        chk("R4 other addr read zero", rd, 8'h00);
        #1 chk("R4 no strobe reads zero", bus_rdata, 8'h00);
        chk("R3 run enable owns", pin_jtag_sel[0], 1'b1);
        bus_write(8'hC7, 8'h00);
        @(negedge clk);
        chk("R3 microcontroller clears", pin_jtag_sel[0], 1'b0);

        // R6: nonvolatile bit only via nv_load
        nv_set(1'b1);
        @(negedge clk);
        chk("R6 nv load owns", pin_jtag_sel[0], 1'b1);
        bus_write(8'hC7, 8'h00);
        bus_write(8'hC6, 8'h00);
        @(negedge clk);
        chk("R6 bus cannot clear nv", pin_jtag_sel[0], 1'b1);
        nv_set(1'b0);
        @(negedge clk);
        chk("R6 nv load clears", pin_jtag_sel[0], 1'b0);

        // R5: reset mid-operation clears run enable and activation
        bus_write(8'hC7, 8'h01);
        @(negedge clk);
        pulse_cmd(1'b1);
        chk("R5 pre-reset active", pad_oe[5:3], 3'b111);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_read(8'hC7, rd);
        chk("R5 reset clears run enable", rd, 8'h00);
        chk("R5 reset clears tdo", pad_oe[3], 1'b0);
        chk("R5 nv back to blank", pin_jtag_sel[3:0], 4'b1111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule